// File: doc/BRIEF.md
# Dual-Limit Watchdog Comparator

This block watches a stream of signed samples and tells the surrounding logic when a sample lies outside a window made of two programmable limits. Samples arrive in sign-magnitude form: one sign bit and an 8-bit magnitude. Each limit is also sign-magnitude. Each limit carries a direction bit that decides whether a sample above it or a sample below it counts as a violation.

When a sample-valid strobe is accepted, the block latches the sample. It then spends one cycle checking it against the first limit and the following cycle checking the same latched sample against the second limit. A violation of either limit sets a sticky flag for that limit. The flag stays set until the consumer clears it through a per-flag clear input.

The limits are loaded through a small write port. The port carries a 2-bit section code and a 16-bit data word. A read port returns the stored limit words so that software-visible state can be checked.

Top module: `wdc_top`

## Requirements
- R1: A write with section code 2'b01 loads limit #1 and a write with code 2'b10 loads limit #2. Data bits [7:0] are the magnitude, bit 8 is the sign (1 = negative) and bit 9 is the direction. A write to one limit leaves the other limit unchanged. Reading with the same section code returns the stored word.
- R2: Data bits [15:10] are not stored and always read back as 0. Writes with section codes 2'b00 and 2'b11 change neither limit.
- R3: A sample is accepted on a clock edge where `smp_valid` is high and `busy` is low. `busy` is then high for exactly two cycles and low afterwards.
- R4: Limit #1 is evaluated in the first busy cycle, so `trip[0]` can become visible one cycle before `trip[1]`. Limit #2 is evaluated in the second busy cycle, so `trip[1]` becomes visible at the edge that ends `busy`.
- R5: With direction bit 1, a limit trips when the sample is strictly greater than it. With direction bit 0, it trips when the sample is strictly smaller.
- R6: The comparison is signed, over the range -255..+255, and negative zero equals positive zero.
- R7: A sample equal to a limit never trips that limit, in either direction.
- R8: `trip[i]` stays set until `trip_clr[i]` is high at a clock edge. A clear of one flag leaves the other flag unchanged. When a new trip and a clear of the same flag meet at the same edge, the flag ends up set.
- R9: `smp_valid` while `busy` is high is ignored: the sample under evaluation does not change.
- R10: After reset, both limits, both flags and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Limit write strobe |
| wr_sect | input | 2 | Section code for the write |
| wr_data | input | 16 | Write data word |
| rd_sect | input | 2 | Section code for the read-back |
| rd_data | output | 16 | Stored word of the selected limit, 0 for other codes |
| smp_valid | input | 1 | Sample strobe |
| smp_neg | input | 1 | Sample sign, 1 = negative |
| smp_mag | input | 8 | Sample magnitude |
| trip_clr | input | 2 | Per-flag clear, bit 0 for limit #1 |
| busy | output | 1 | High during the two compare cycles |
| trip | output | 2 | Sticky flags, bit 0 for limit #1, bit 1 for limit #2 |

## Verification
The bench aims at the points where a sign-magnitude comparator usually breaks. It places samples exactly on a limit, which must not trip in either direction. It compares negative zero against a zero limit; a design that compares the raw encodings would call -0 smaller than +0. It also uses limits of both signs with samples near the 8-bit extremes, where an unsigned compare trips the wrong flag. Cycle-exact sampling of `trip` and `busy` exposes designs that swap the order of the two limits or stay busy for the wrong number of cycles. Directed cases hold a clear against a fresh trip, strobe a second sample mid-compare, and write to the unused sections or the unused data bits; a design that gets these wrong loses an event, evaluates the wrong sample, or corrupts a limit.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

    parameter int MAG_W   = 8;
    parameter int REG_W   = 16;
    parameter int NUM_LIM = 2;
    parameter int SEL_W   = 2;

    localparam int LIM_W = MAG_W + 2;
    localparam int PAD_W = REG_W - LIM_W;
    localparam int SMP_W = MAG_W + 1;

    typedef enum logic [SEL_W-1:0] {
        SEC_CTRL = 2'b00,
        SEC_LIM1 = 2'b01,
        SEC_LIM2 = 2'b10,
        SEC_RSVD = 2'b11
    } sect_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMP1 = 2'd1,
        ST_CMP2 = 2'd2
    } step_e;

    typedef struct packed {
        logic             dir;
        logic             neg;
        logic [MAG_W-1:0] mag;
    } limit_t;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } sample_t;

    // sign-magnitude to two's complement; -0 and +0 both map to 0
    function automatic logic signed [MAG_W:0] sm_to_int(input logic neg,
                                                        input logic [MAG_W-1:0] mag);
        logic signed [MAG_W:0] ext;
        ext = $signed({1'b0, mag});
        return neg ? -ext : ext;
    endfunction

    function automatic logic limit_trips(input sample_t s, input limit_t l);
        logic signed [MAG_W:0] sv;
        logic signed [MAG_W:0] lv;
        sv = sm_to_int(s.neg, s.mag);
        lv = sm_to_int(l.neg, l.mag);
        return l.dir ? (sv > lv) : (sv < lv);
    endfunction

endpackage

// File: rtl/wdc_limit_bank.sv
module wdc_limit_bank
    import wdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sect,
    input  logic [REG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sect,
    output logic [REG_W-1:0] rd_data,
    output limit_t           lim_q [NUM_LIM]
);

    logic [PAD_W-1:0] pad_bits;
    assign pad_bits = wr_data[REG_W-1:LIM_W];

    for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g + 1);

        always_ff @(posedge clk) begin
            if (rst) begin
                lim_q[g] <= '0;
            end else if (wr_en && wr_sect == MY_SEL) begin
                lim_q[g] <= limit_t'(wr_data[LIM_W-1:0]);
            end
        end

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
            wr_en && wr_sect == MY_SEL |=> lim_q[g] == limit_t'($past(wr_data[LIM_W-1:0]))); // R1

        AST_OTHER_SECT_IGNORED: assert property (@(posedge clk) disable iff (rst)
            wr_en && wr_sect != MY_SEL |=> $stable(lim_q[g])); // R2

        AST_PAD_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
            wr_en && wr_sect == MY_SEL && pad_bits != '0 |=> rd_sect != MY_SEL || rd_data[REG_W-1:LIM_W] == '0); // R2
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_LIM; i++) begin
            if (rd_sect == SEL_W'(i + 1)) begin
                rd_data = {{PAD_W{1'b0}}, lim_q[i]};
            end
        end
    end

endmodule

// File: rtl/wdc_seq.sv
module wdc_seq
    import wdc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    smp_valid,
    input  sample_t smp_in,
    output step_e   step_q,
    output sample_t smp_q,
    output logic    busy
);

    assign busy = (step_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_IDLE;
            smp_q  <= '0;
        end else begin
            unique case (step_q)
                ST_IDLE: begin
                    if (smp_valid) begin
                        smp_q  <= smp_in;
                        step_q <= ST_CMP1;
                    end
                end
                ST_CMP1: step_q <= ST_CMP2;
                default: step_q <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_ENTER: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy); // R3

    AST_BUSY_LEAVE: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |=> !busy); // R3

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy && smp_valid |=> busy); // R3

    AST_HOLD_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(smp_q)); // R9

endmodule

// File: rtl/wdc_flags.sv
module wdc_flags
    import wdc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  step_e              step_q,
    input  sample_t            smp_q,
    input  limit_t             lim_q [NUM_LIM],
    input  logic [NUM_LIM-1:0] trip_clr,
    output logic [NUM_LIM-1:0] trip
);

    for (genvar g = 0; g < NUM_LIM; g++) begin : g_flag
        localparam step_e MY_STEP = step_e'(2'(g + 1));
        logic hit;

        assign hit = (step_q == MY_STEP) && limit_trips(smp_q, lim_q[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                trip[g] <= 1'b0;
            end else if (hit) begin
                trip[g] <= 1'b1;
            end else if (trip_clr[g]) begin
                trip[g] <= 1'b0;
            end
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            trip[g] && !trip_clr[g] |=> trip[g]); // R8

        AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (rst)
            $rose(trip[g]) |-> $past(step_q) == MY_STEP); // R4

        AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
            hit && trip_clr[g] |=> trip[g]); // R8
    end

endmodule

// File: rtl/wdc_top.sv
module wdc_top
    import wdc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sect,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]   rd_sect,
    output logic [REG_W-1:0]   rd_data,
    input  logic               smp_valid,
    input  logic               smp_neg,
    input  logic [MAG_W-1:0]   smp_mag,
    input  logic [NUM_LIM-1:0] trip_clr,
    output logic               busy,
    output logic [NUM_LIM-1:0] trip
);

    limit_t  lim_q [NUM_LIM];
    sample_t smp_in;
    sample_t smp_q;
    step_e   step_q;

    assign smp_in = '{neg: smp_neg, mag: smp_mag};

    wdc_limit_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sect (wr_sect),
        .wr_data (wr_data),
        .rd_sect (rd_sect),
        .rd_data (rd_data),
        .lim_q   (lim_q)
    );

    wdc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_in    (smp_in),
        .step_q    (step_q),
        .smp_q     (smp_q),
        .busy      (busy)
    );

    wdc_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .step_q   (step_q),
        .smp_q    (smp_q),
        .lim_q    (lim_q),
        .trip_clr (trip_clr),
        .trip     (trip)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !busy && trip == '0); // R10

endmodule

// File: tb/sim_wdc_top.sv
`timescale 1ns/1ps
module sim_wdc_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sect;
    logic [15:0] wr_data;
    logic [1:0]  rd_sect;
    logic [15:0] rd_data;
    logic        smp_valid;
    logic        smp_neg;
    logic [7:0]  smp_mag;
    logic [1:0]  trip_clr;
    logic        busy;
    logic [1:0]  trip;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wdc_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sect(wr_sect), .wr_data(wr_data),
        .rd_sect(rd_sect), .rd_data(rd_data), .smp_valid(smp_valid), .smp_neg(smp_neg),
        .smp_mag(smp_mag), .trip_clr(trip_clr), .busy(busy), .trip(trip)
    );

    // {limit1[9:0], limit2[9:0], sample{neg,mag}[8:0], expected trip[1:0]}
    // limit word: bit9 direction (1 = above trips), bit8 sign, bits7:0 magnitude
    localparam int NV = 10;
    localparam logic [30:0] VEC [NV] = '{
        {10'h20A, 10'h10A, 9'h014, 2'b01},  // +20 vs >+10, <-10
        {10'h20A, 10'h10A, 9'h114, 2'b10},  // -20
        {10'h20A, 10'h10A, 9'h00A, 2'b00},  // equal to limit #1
        {10'h20A, 10'h10A, 9'h10A, 2'b00},  // equal to limit #2
        {10'h200, 10'h100, 9'h100, 2'b00},  // -0 vs >+0, <-0
        {10'h200, 10'h100, 9'h001, 2'b01},  // +1
        {10'h200, 10'h100, 9'h101, 2'b10},  // -1
        {10'h105, 10'h264, 9'h1C8, 2'b01},  // -200 vs <-5, >+100
        {10'h105, 10'h264, 9'h0FF, 2'b10},  // +255
        {10'h332, 10'h032, 9'h000, 2'b11}   // 0 vs >-50, <+50
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sect, input logic [15:0] data);
        wr_en = 1'b1; wr_sect = sect; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sect, output logic [15:0] data);
        rd_sect = sect;
        #1 data = rd_data;
    endtask

    task automatic clear_all();
        trip_clr = 2'b11;
        @(negedge clk);
        trip_clr = 2'b00;
    endtask

    task automatic fire(input logic neg, input logic [7:0] mag);
        smp_valid = 1'b1; smp_neg = neg; smp_mag = mag;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        rst = 1'b1; wr_en = 1'b0; wr_sect = '0; wr_data = '0; rd_sect = '0;
        smp_valid = 1'b0; smp_neg = 1'b0; smp_mag = '0; trip_clr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        chk("R10 busy", 16'(busy), 16'h0);
        chk("R10 trip", 16'(trip), 16'h0);
        rd(2'b01, v); chk("R10 limit1", v, 16'h0);
        rd(2'b10, v); chk("R10 limit2", v, 16'h0);

        // R5/R6/R7: vector table
        for (int i = 0; i < NV; i++) begin
            clear_all();
            wr(2'b01, {6'b0, VEC[i][30:21]});
            wr(2'b10, {6'b0, VEC[i][20:11]});
            fire(VEC[i][10], VEC[i][9:2]);
            chk($sformatf("R5/R6/R7 vector %0d", i), 16'(trip), 16'(VEC[i][1:0]));
        end

        // R1: write selection and read-back
        wr(2'b01, 16'h0123);
        rd(2'b01, v); chk("R1 limit1 written", v, 16'h0123);
        rd(2'b10, v); chk("R1 limit2 untouched", v, 16'h0032);

        // R2: upper bits dropped, sections 00 and 11 ignored
        wr(2'b01, 16'hFFFF);
        rd(2'b01, v); chk("R2 upper bits zero", v, 16'h03FF);
        wr(2'b00, 16'h0155);
        wr(2'b11, 16'h0155);
        rd(2'b01, v); chk("R2 limit1 after 00/11", v, 16'h03FF);
        rd(2'b10, v); chk("R2 limit2 after 00/11", v, 16'h0032);

        // R3/R4: busy window and comparison order
        wr(2'b01, 16'h0200);   // above +0 trips
        wr(2'b10, 16'h0064);   // below +100 trips
        clear_all();
        smp_valid = 1'b1; smp_neg = 1'b0; smp_mag = 8'd5;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R3 busy first cycle", 16'(busy), 16'h1);
        chk("R4 no flag yet", 16'(trip), 16'h0);
        @(negedge clk);
        chk("R3 busy second cycle", 16'(busy), 16'h1);
        chk("R4 limit1 first", 16'(trip), 16'h1);
        @(negedge clk);
        chk("R3 busy ends", 16'(busy), 16'h0);
        chk("R4 limit2 second", 16'(trip), 16'h3);

        // R8: sticky, per-flag clear, set beats clear
        wr(2'b10, 16'h0164);   // below -100 trips
        fire(1'b1, 8'd0);      // -0 trips neither
        chk("R8 flags sticky", 16'(trip), 16'h3);
        trip_clr = 2'b01;
        @(negedge clk);
        chk("R8 clear bit0 only", 16'(trip), 16'h2);
        smp_valid = 1'b1; smp_neg = 1'b0; smp_mag = 8'd5;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        chk("R8 set wins over clear", 16'(trip), 16'h3);
        @(negedge clk);
        chk("R8 clear after set", 16'(trip), 16'h2);
        trip_clr = 2'b00;

        // R9: strobe while busy is ignored
        clear_all();
        smp_valid = 1'b1; smp_neg = 1'b1; smp_mag = 8'd0;
        @(negedge clk);
        smp_neg = 1'b0; smp_mag = 8'd5;   // would trip limit1 if taken
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        chk("R9 busy done", 16'(busy), 16'h0);
        chk("R9 mid-compare strobe ignored", 16'(trip), 16'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule